// File: doc/BRIEF.md
# Machine/Supervisor Control Register File

This block holds the privileged control and status registers of a processor hart at machine and supervisor level. A single port presents a 12-bit register address, a write word and a write strobe. The read word and an illegal-address flag follow the address combinationally. Each register filters what software writes to it. Some bits are fixed. Some fields accept only legal encodings and otherwise keep their old value. Some bits are derived from other bits rather than stored.

The supervisor status, pending and enable registers do not hold their own state. They are restricted windows onto the machine registers. The user-visible time and retired-instruction counters are the free-running inputs plus a stored offset, and writing them rewrites that offset. A pair of mailbox registers passes words to and from a host: the outbound word is exposed on a port and is cleared by the host.

Top module: `priv_csr_file`

## Requirements
- R1: A write to machine status (0x300) changes only bits 1, 3, 5, 7 and 8, the FP state field [14:13], bit 17 and bit 18. The extension state field [16:15] changes only when HAS_EXT is 1. Every other bit keeps its value.
- R2: The previous-privilege field [12:11] ignores the value 2. The translation mode field [28:24] accepts 0, plus 8 when XLEN is 32, or 9 and 10 when XLEN is 64. Any other value leaves that field unchanged.
- R3: Bit XLEN-1 of machine status is recomputed on every status write. It is 1 exactly when [14:13] or [16:15] equals 3.
- R4: Supervisor status (0x100) reads machine status masked to bits 1, 5, 8, 18, [14:13], [16:15] and XLEN-1. A write to it changes only bits 1, 5, 8, 18, [14:13] and [16:15], under the R1–R3 rules.
- R5: Machine pending (0x344) accepts writes to bits 1, 3, 5 and 8, and a write never changes the timer bit 7. Machine enable (0x304) stores bits 1, 3, 5, 7 and 8. Delegation (0x303) stores only bits 1 and 5.
- R6: Supervisor pending (0x144) reads machine pending bits 1 and 5, and a write changes only bit 1. Supervisor enable (0x104) reads and writes machine enable bits 1 and 5 only.
- R7: The supervisor vector (0x105) stores the written word with bits [1:0] cleared. The machine vector (0x305) always reads MTVEC_VAL and ignores writes. Registers 0x340, 0x341, 0x342, 0x140, 0x141 and 0x142 store the full word.
- R8: The timer compare register (0x321) resets to all ones. Pending bit 7 becomes 1 at the first edge where the low XLEN bits of the real-time input are at least the compare value, and it stays set. A compare write clears it at that edge.
- R9: The machine time register (0x701) reads the low XLEN bits of the real-time input. Writes to it change nothing.
- R10: User time (0xC01, high half 0xC81 only when XLEN is 32) reads real-time plus a 64-bit offset. A low write sets the offset so that the low word reads the written value; when XLEN is 32, this keeps the offset's high word. A high write stores the high word of (value<<32 minus real-time) into the offset's high word.
- R11: The user retired count (0xC02, high half 0xC82) applies the R10 rules to the retired-instruction input with its own offset.
- R12: The outbound mailbox (0x780, shown on tohost_o) accepts a write only while it holds zero. tohost_clr_i sets it to zero.
- R13: A write to the inbound mailbox (0x781) stores the word, sets pending bit 8 when the word is non-zero, and clears bit 8 otherwise.
- R14: Any other address raises illegal_o and reads zero. A write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Register address |
| wdata_i | input | XLEN | Write word |
| we_i | input | 1 | Write strobe, applied at the rising edge |
| rtc_i | input | 64 | Real-time counter |
| instret_i | input | 64 | Retired-instruction counter |
| tohost_clr_i | input | 1 | Host clears the outbound mailbox |
| rdata_o | output | XLEN | Read word for addr_i |
| illegal_o | output | 1 | Address not implemented |
| tohost_o | output | XLEN | Outbound mailbox contents |

## Verification
The bench builds the block with XLEN = 32 and HAS_EXT = 0. With XLEN = 32, the separate high-half counter writes and the borrow between offset words can be reached, and the legal translation mode set is {0, 8}. With HAS_EXT = 0, writes to the extension field can be shown to have no effect, so the summary bit can only come from the FP field. The 64-bit real-time input is set above 2^32 so that the high half reads non-zero.

// File: rtl/priv_csr_pkg.sv
package priv_csr_pkg;

    localparam logic [11:0] A_MSTATUS   = 12'h300;
    localparam logic [11:0] A_MDELEG    = 12'h303;
    localparam logic [11:0] A_MIE       = 12'h304;
    localparam logic [11:0] A_MTVEC     = 12'h305;
    localparam logic [11:0] A_MTIMECMP  = 12'h321;
    localparam logic [11:0] A_MSCRATCH  = 12'h340;
    localparam logic [11:0] A_MEPC      = 12'h341;
    localparam logic [11:0] A_MCAUSE    = 12'h342;
    localparam logic [11:0] A_MIP       = 12'h344;
    localparam logic [11:0] A_SSTATUS   = 12'h100;
    localparam logic [11:0] A_SIE       = 12'h104;
    localparam logic [11:0] A_STVEC     = 12'h105;
    localparam logic [11:0] A_SSCRATCH  = 12'h140;
    localparam logic [11:0] A_SEPC      = 12'h141;
    localparam logic [11:0] A_SCAUSE    = 12'h142;
    localparam logic [11:0] A_SIP       = 12'h144;
    localparam logic [11:0] A_MTIME     = 12'h701;
    localparam logic [11:0] A_TOHOST    = 12'h780;
    localparam logic [11:0] A_FROMHOST  = 12'h781;
    localparam logic [11:0] A_UTIME     = 12'hC01;
    localparam logic [11:0] A_URET      = 12'hC02;
    localparam logic [11:0] A_UTIMEH    = 12'hC81;
    localparam logic [11:0] A_URETH     = 12'hC82;

    // status bit positions
    localparam int B_SIE  = 1;
    localparam int B_MIE  = 3;
    localparam int B_SPIE = 5;
    localparam int B_MPIE = 7;
    localparam int B_SPP  = 8;
    localparam int B_MPP  = 11;  // [12:11]
    localparam int B_FS   = 13;  // [14:13]
    localparam int B_XS   = 15;  // [16:15]
    localparam int B_MPRV = 17;
    localparam int B_PUM  = 18;
    localparam int B_VM   = 24;  // [28:24]

    // interrupt bit positions
    localparam int B_SSIP = 1;
    localparam int B_MSIP = 3;
    localparam int B_STIP = 5;
    localparam int B_MTIP = 7;
    localparam int B_HOST = 8;

    typedef enum logic [4:0] {
        S_NONE, S_MSTATUS, S_SSTATUS, S_MIP, S_MIE, S_SIP, S_SIE, S_MDELEG,
        S_MEPC, S_MSCRATCH, S_MCAUSE, S_MTVEC, S_SEPC, S_SSCRATCH, S_SCAUSE,
        S_STVEC, S_MTIME, S_MTIMECMP, S_UTIME, S_UTIMEH, S_URET, S_URETH,
        S_TOHOST, S_FROMHOST
    } csr_sel_e;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import priv_csr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [11:0] addr_i,
    output csr_sel_e    sel_o,
    output logic        illegal_o
);
    localparam bit HAS_HI = (XLEN == 32);

    always_comb begin
        case (addr_i)
            A_MSTATUS:  sel_o = S_MSTATUS;
            A_SSTATUS:  sel_o = S_SSTATUS;
            A_MIP:      sel_o = S_MIP;
            A_MIE:      sel_o = S_MIE;
            A_SIP:      sel_o = S_SIP;
            A_SIE:      sel_o = S_SIE;
            A_MDELEG:   sel_o = S_MDELEG;
            A_MEPC:     sel_o = S_MEPC;
            A_MSCRATCH: sel_o = S_MSCRATCH;
            A_MCAUSE:   sel_o = S_MCAUSE;
            A_MTVEC:    sel_o = S_MTVEC;
            A_SEPC:     sel_o = S_SEPC;
            A_SSCRATCH: sel_o = S_SSCRATCH;
            A_SCAUSE:   sel_o = S_SCAUSE;
            A_STVEC:    sel_o = S_STVEC;
            A_MTIME:    sel_o = S_MTIME;
            A_MTIMECMP: sel_o = S_MTIMECMP;
            A_UTIME:    sel_o = S_UTIME;
            A_URET:     sel_o = S_URET;
            A_UTIMEH:   sel_o = HAS_HI ? S_UTIMEH : S_NONE;
            A_URETH:    sel_o = HAS_HI ? S_URETH : S_NONE;
            A_TOHOST:   sel_o = S_TOHOST;
            A_FROMHOST: sel_o = S_FROMHOST;
            default:    sel_o = S_NONE;
        endcase
        illegal_o = (sel_o == S_NONE);
    end
endmodule

// File: rtl/csr_status_warl.sv
module csr_status_warl
    import priv_csr_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit HAS_EXT = 1'b0
) (
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] wval_i,
    output logic [XLEN-1:0] new_o
);
    localparam logic [XLEN-1:0] FIXED_MSK =
        (XLEN'(1) << B_SIE)  | (XLEN'(1) << B_MIE)  | (XLEN'(1) << B_SPIE) |
        (XLEN'(1) << B_MPIE) | (XLEN'(1) << B_SPP)  | (XLEN'(3) << B_FS)   |
        (XLEN'(1) << B_MPRV) | (XLEN'(1) << B_PUM);
    localparam logic [XLEN-1:0] XS_MSK  = XLEN'(3) << B_XS;
    localparam logic [XLEN-1:0] MPP_MSK = XLEN'(3) << B_MPP;
    localparam logic [XLEN-1:0] VM_MSK  = XLEN'(31) << B_VM;

    logic [4:0]      vm_w;
    logic [1:0]      mpp_w;
    logic            vm_ok;
    logic [XLEN-1:0] msk;
    logic [XLEN-1:0] merged;

    always_comb begin
        vm_w  = wval_i[B_VM +: 5];
        mpp_w = wval_i[B_MPP +: 2];
        if (XLEN == 32) vm_ok = (vm_w == 5'd0) || (vm_w == 5'd8);
        else            vm_ok = (vm_w == 5'd0) || (vm_w == 5'd9) || (vm_w == 5'd10);
        msk = FIXED_MSK;
        if (HAS_EXT)        msk = msk | XS_MSK;
        if (vm_ok)          msk = msk | VM_MSK;
        if (mpp_w != 2'd2)  msk = msk | MPP_MSK;
        merged = (old_i & ~msk) | (wval_i & msk);
        new_o  = merged;
        new_o[XLEN-1] = (merged[B_FS +: 2] == 2'b11) || (merged[B_XS +: 2] == 2'b11);
    end
endmodule

// File: rtl/csr_delta_counter.sv
module csr_delta_counter #(
    parameter int XLEN = 64
) (
    input  logic [63:0]     base_i,
    input  logic [63:0]     delta_q_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            wr_lo_i,
    input  logic            wr_hi_i,
    output logic [XLEN-1:0] rd_lo_o,
    output logic [31:0]     rd_hi_o,
    output logic [63:0]     delta_d_o
);
    logic [63:0] sum;
    logic [63:0] diff_lo;
    logic [63:0] diff_hi;

    always_comb begin
        sum     = base_i + delta_q_i;
        rd_lo_o = sum[XLEN-1:0];
        rd_hi_o = sum[63:32];
        diff_lo = 64'(wdata_i) - base_i;
        diff_hi = {wdata_i[31:0], 32'b0} - base_i;
    end

    generate
        if (XLEN == 32) begin : g_split
            always_comb begin
                delta_d_o = delta_q_i;
                if (wr_lo_i)      delta_d_o = {delta_q_i[63:32], diff_lo[31:0]};
                else if (wr_hi_i) delta_d_o = {diff_hi[63:32], delta_q_i[31:0]};
            end
        end else begin : g_full
            always_comb begin
                delta_d_o = delta_q_i;
                if (wr_lo_i) delta_d_o = diff_lo;
            end
        end
    endgenerate
endmodule

// File: rtl/priv_csr_file.sv
module priv_csr_file
    import priv_csr_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter bit              HAS_EXT   = 1'b0,
    parameter logic [XLEN-1:0] MTVEC_VAL = XLEN'(32'h100)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     addr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            we_i,
    input  logic [63:0]     rtc_i,
    input  logic [63:0]     instret_i,
    input  logic            tohost_clr_i,
    output logic [XLEN-1:0] rdata_o,
    output logic            illegal_o,
    output logic [XLEN-1:0] tohost_o
);
    localparam logic [XLEN-1:0] I_SSIP = XLEN'(1) << B_SSIP;
    localparam logic [XLEN-1:0] I_MSIP = XLEN'(1) << B_MSIP;
    localparam logic [XLEN-1:0] I_STIP = XLEN'(1) << B_STIP;
    localparam logic [XLEN-1:0] I_MTIP = XLEN'(1) << B_MTIP;
    localparam logic [XLEN-1:0] I_HOST = XLEN'(1) << B_HOST;
    localparam logic [XLEN-1:0] I_ALL  = I_SSIP | I_MSIP | I_STIP | I_MTIP | I_HOST;
    localparam logic [XLEN-1:0] I_SUP  = I_SSIP | I_STIP;
    localparam logic [XLEN-1:0] SV_MSK =
        (XLEN'(1) << B_SIE) | (XLEN'(1) << B_SPIE) | (XLEN'(1) << B_SPP) |
        (XLEN'(3) << B_FS)  | (XLEN'(3) << B_XS)   | (XLEN'(1) << B_PUM);
    localparam logic [XLEN-1:0] SD_BIT = XLEN'(1) << (XLEN - 1);

    typedef struct packed {
        logic [XLEN-1:0] mstatus;
        logic [XLEN-1:0] mip;
        logic [XLEN-1:0] mie;
        logic [XLEN-1:0] mdeleg;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mscratch;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] sscratch;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] stvec;
        logic [XLEN-1:0] mtimecmp;
        logic [XLEN-1:0] tohost;
        logic [XLEN-1:0] fromhost;
        logic [63:0]     tdelta;
        logic [63:0]     idelta;
    } csr_state_t;

    csr_state_t      st_d, st_q;
    csr_sel_e        sel;
    logic            bad_addr;
    logic [XLEN-1:0] status_wval;
    logic [XLEN-1:0] status_new;
    logic [XLEN-1:0] t_lo, i_lo;
    logic [31:0]     t_hi, i_hi;
    logic [63:0]     tdelta_nx, idelta_nx;
    logic            wr_any;

    assign wr_any = we_i && !bad_addr;

    csr_addr_decode #(.XLEN(XLEN)) u_dec (
        .addr_i    (addr_i),
        .sel_o     (sel),
        .illegal_o (bad_addr)
    );

    assign status_wval = (sel == S_SSTATUS)
                       ? ((st_q.mstatus & ~SV_MSK) | (wdata_i & SV_MSK))
                       : wdata_i;

    csr_status_warl #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_status (
        .old_i  (st_q.mstatus),
        .wval_i (status_wval),
        .new_o  (status_new)
    );

    csr_delta_counter #(.XLEN(XLEN)) u_time (
        .base_i    (rtc_i),
        .delta_q_i (st_q.tdelta),
        .wdata_i   (wdata_i),
        .wr_lo_i   (wr_any && sel == S_UTIME),
        .wr_hi_i   (wr_any && sel == S_UTIMEH),
        .rd_lo_o   (t_lo),
        .rd_hi_o   (t_hi),
        .delta_d_o (tdelta_nx)
    );

    csr_delta_counter #(.XLEN(XLEN)) u_ret (
        .base_i    (instret_i),
        .delta_q_i (st_q.idelta),
        .wdata_i   (wdata_i),
        .wr_lo_i   (wr_any && sel == S_URET),
        .wr_hi_i   (wr_any && sel == S_URETH),
        .rd_lo_o   (i_lo),
        .rd_hi_o   (i_hi),
        .delta_d_o (idelta_nx)
    );

    // next-state computation
    always_comb begin
        st_d        = st_q;
        st_d.tdelta = tdelta_nx;
        st_d.idelta = idelta_nx;
        if (rtc_i[XLEN-1:0] >= st_q.mtimecmp) st_d.mip = st_d.mip | I_MTIP;
        if (tohost_clr_i) st_d.tohost = '0;
        if (wr_any) begin
            case (sel)
                S_MSTATUS, S_SSTATUS: st_d.mstatus = status_new;
                S_MIP:      st_d.mip  = (st_d.mip & ~(I_ALL & ~I_MTIP)) | (wdata_i & (I_ALL & ~I_MTIP));
                S_SIP:      st_d.mip  = (st_d.mip & ~I_SSIP) | (wdata_i & I_SSIP);
                S_MIE:      st_d.mie  = (st_q.mie & ~I_ALL) | (wdata_i & I_ALL);
                S_SIE:      st_d.mie  = (st_q.mie & ~I_SUP) | (wdata_i & I_SUP);
                S_MDELEG:   st_d.mdeleg = wdata_i & I_SUP;
                S_MEPC:     st_d.mepc     = wdata_i;
                S_MSCRATCH: st_d.mscratch = wdata_i;
                S_MCAUSE:   st_d.mcause   = wdata_i;
                S_SEPC:     st_d.sepc     = wdata_i;
                S_SSCRATCH: st_d.sscratch = wdata_i;
                S_SCAUSE:   st_d.scause   = wdata_i;
                S_STVEC:    st_d.stvec    = {wdata_i[XLEN-1:2], 2'b00};
                S_MTIMECMP: begin
                    st_d.mtimecmp = wdata_i;
                    st_d.mip      = st_d.mip & ~I_MTIP;
                end
                S_TOHOST:   if (st_q.tohost == '0 && !tohost_clr_i) st_d.tohost = wdata_i;
                S_FROMHOST: begin
                    st_d.fromhost = wdata_i;
                    st_d.mip      = (|wdata_i) ? (st_d.mip | I_HOST) : (st_d.mip & ~I_HOST);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mtimecmp <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // read path
    always_comb begin
        case (sel)
            S_MSTATUS:  rdata_o = st_q.mstatus;
            S_SSTATUS:  rdata_o = st_q.mstatus & (SV_MSK | SD_BIT);
            S_MIP:      rdata_o = st_q.mip;
            S_SIP:      rdata_o = st_q.mip & I_SUP;
            S_MIE:      rdata_o = st_q.mie;
            S_SIE:      rdata_o = st_q.mie & I_SUP;
            S_MDELEG:   rdata_o = st_q.mdeleg;
            S_MEPC:     rdata_o = st_q.mepc;
            S_MSCRATCH: rdata_o = st_q.mscratch;
            S_MCAUSE:   rdata_o = st_q.mcause;
            S_MTVEC:    rdata_o = MTVEC_VAL;
            S_SEPC:     rdata_o = st_q.sepc;
            S_SSCRATCH: rdata_o = st_q.sscratch;
            S_SCAUSE:   rdata_o = st_q.scause;
            S_STVEC:    rdata_o = st_q.stvec;
            S_MTIME:    rdata_o = rtc_i[XLEN-1:0];
            S_MTIMECMP: rdata_o = st_q.mtimecmp;
            S_UTIME:    rdata_o = t_lo;
            S_UTIMEH:   rdata_o = XLEN'(t_hi);
            S_URET:     rdata_o = i_lo;
            S_URETH:    rdata_o = XLEN'(i_hi);
            S_TOHOST:   rdata_o = st_q.tohost;
            S_FROMHOST: rdata_o = st_q.fromhost;
            default:    rdata_o = '0;
        endcase
    end

    assign illegal_o = bad_addr;
    assign tohost_o  = st_q.tohost;

    // assertions
    p_mpp_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mstatus[B_MPP +: 2] != 2'd2);
    p_sd_derived_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mstatus[XLEN-1] == ((st_q.mstatus[B_FS +: 2] == 2'b11) || (st_q.mstatus[B_XS +: 2] == 2'b11)));
    p_xs_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_EXT |-> (st_q.mstatus[B_XS +: 2] == 2'b00));
    p_deleg_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mdeleg & ~I_SUP) == '0);
    p_stvec_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stvec[1:0] == 2'b00);
    p_cmp_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == S_MTIMECMP) |=> !st_q.mip[B_MTIP]);
    p_tohost_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tohost != '0 && !tohost_clr_i) |=> $stable(st_q.tohost));
    p_host_irq_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == S_FROMHOST) |=> (st_q.mip[B_HOST] == (st_q.fromhost != '0)));
    p_illegal_read_r14: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (rdata_o == '0));
endmodule

// File: tb/sim_priv_csr_file.sv
module sim_priv_csr_file;
    localparam int XL = 32;
    localparam logic [31:0] MTV = 32'h0000_0100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   addr = '0;
    logic [XL-1:0] wdata = '0;
    logic          we = 1'b0;
    logic [63:0]   rtc = '0;
    logic [63:0]   iret = '0;
    logic          tclr = 1'b0;
    logic [XL-1:0] rdata;
    logic          ill;
    logic [XL-1:0] tohost;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    priv_csr_file #(.XLEN(XL), .HAS_EXT(1'b0), .MTVEC_VAL(MTV)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
        .rtc_i(rtc), .instret_i(iret), .tohost_clr_i(tclr),
        .rdata_o(rdata), .illegal_o(ill), .tohost_o(tohost)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 reset status", 12'h300, 32'h0);
        rd_chk("R7 mtvec const", 12'h305, MTV);
        rd_chk("R8 cmp reset ones", 12'h321, 32'hFFFF_FFFF);
        rd_chk("R5 mip reset", 12'h344, 32'h0);
        chk("R12 tohost reset", tohost, 32'h0);
    endtask

    task automatic t_status;
        wr(12'h300, 32'hFFFF_FFFF);
        rd_chk("R1 status mask", 12'h300, 32'h8006_79AA);
        wr(12'h300, 32'h0800_0800);
        rd_chk("R2 legal vm/mpp", 12'h300, 32'h0800_0800);
        wr(12'h300, 32'h0900_1000);
        rd_chk("R2 illegal vm/mpp kept", 12'h300, 32'h0800_0800);
        wr(12'h300, 32'h0);
        wr(12'h300, 32'h0001_8000);
        rd_chk("R1 xs locked", 12'h300, 32'h0);
        wr(12'h300, 32'h0000_4000);
        rd_chk("R3 fs=2 no sd", 12'h300, 32'h0000_4000);
        wr(12'h300, 32'h0000_6000);
        rd_chk("R3 fs=3 sets sd", 12'h300, 32'h8000_6000);
    endtask

    task automatic t_sview;
        wr(12'h300, 32'h0);
        wr(12'h100, 32'hFFFF_FFFF);
        rd_chk("R4 sstatus read", 12'h100, 32'h8004_6122);
        rd_chk("R4 mstatus via sview", 12'h300, 32'h8004_6122);
        wr(12'h300, 32'h0000_0008);
        rd_chk("R4 mie hidden", 12'h100, 32'h0);
        rd_chk("R4 mie set", 12'h300, 32'h0000_0008);
    endtask

    task automatic t_irq;
        wr(12'h344, 32'hFFFF_FFFF);
        rd_chk("R5 mip mask", 12'h344, 32'h0000_012A);
        wr(12'h303, 32'hFFFF_FFFF);
        rd_chk("R5 deleg mask", 12'h303, 32'h0000_0022);
        wr(12'h304, 32'hFFFF_FFFF);
        rd_chk("R5 mie mask", 12'h304, 32'h0000_01AA);
        rd_chk("R6 sie view", 12'h104, 32'h0000_0022);
        wr(12'h104, 32'h0);
        rd_chk("R6 sie write", 12'h304, 32'h0000_0188);
        wr(12'h344, 32'h0000_0020);
        wr(12'h144, 32'hFFFF_FFFF);
        rd_chk("R6 sip sets ssip only", 12'h344, 32'h0000_0022);
        wr(12'h144, 32'h0);
        rd_chk("R6 sip read", 12'h144, 32'h0000_0020);
        wr(12'h344, 32'h0);
    endtask

    task automatic t_regs;
        wr(12'h105, 32'h0000_1237);
        rd_chk("R7 stvec align", 12'h105, 32'h0000_1234);
        wr(12'h305, 32'h0000_5555);
        rd_chk("R7 mtvec ignores write", 12'h305, MTV);
        wr(12'h340, 32'hDEAD_BEEF);
        rd_chk("R7 mscratch", 12'h340, 32'hDEAD_BEEF);
        wr(12'h142, 32'h8000_0003);
        rd_chk("R7 scause", 12'h142, 32'h8000_0003);
    endtask

    task automatic t_timer;
        wr(12'h321, 32'd5);
        rd_chk("R8 below cmp", 12'h344, 32'h0);
        @(negedge clk); rtc = 64'd5;
        @(negedge clk);
        rd_chk("R8 mtip set", 12'h344, 32'h0000_0080);
        wr(12'h344, 32'h0);
        rd_chk("R5 mip write keeps mtip", 12'h344, 32'h0000_0080);
        wr(12'h321, 32'd100);
        rd_chk("R8 cmp write clears", 12'h344, 32'h0);
        @(negedge clk);
        rd_chk("R8 stays clear", 12'h344, 32'h0);
    endtask

    task automatic t_time;
        @(negedge clk); rtc = 64'h1_0000_0000;
        rd_chk("R9 mtime reads rtc", 12'h701, 32'h0);
        rd_chk("R10 utime hi reset", 12'hC81, 32'h1);
        wr(12'h701, 32'h1234);
        rd_chk("R9 mtime write ignored", 12'hC01, 32'h0);
        wr(12'hC01, 32'h100);
        rd_chk("R10 utime lo", 12'hC01, 32'h100);
        rd_chk("R10 utime hi kept", 12'hC81, 32'h1);
        wr(12'hC81, 32'h7);
        rd_chk("R10 utime hi write", 12'hC81, 32'h7);
        rd_chk("R10 utime lo kept", 12'hC01, 32'h100);
        @(negedge clk); rtc = 64'h1_0000_0003;
        rd_chk("R10 utime tracks rtc", 12'hC01, 32'h103);
    endtask

    task automatic t_ret;
        @(negedge clk); iret = 64'd50;
        wr(12'hC02, 32'd10);
        rd_chk("R11 instret write", 12'hC02, 32'd10);
        @(negedge clk); iret = 64'd60;
        rd_chk("R11 instret tracks", 12'hC02, 32'd20);
        wr(12'hC82, 32'd3);
        rd_chk("R11 instret hi", 12'hC82, 32'd3);
    endtask

    task automatic t_host;
        wr(12'h780, 32'd5);
        #1 chk("R12 tohost write", tohost, 32'd5);
        wr(12'h780, 32'd9);
        #1 chk("R12 tohost held", tohost, 32'd5);
        @(negedge clk); tclr = 1'b1;
        @(negedge clk); tclr = 1'b0;
        #1 chk("R12 tohost cleared", tohost, 32'd0);
        wr(12'h780, 32'd9);
        #1 chk("R12 tohost rewrite", tohost, 32'd9);
        wr(12'h781, 32'd3);
        rd_chk("R13 fromhost value", 12'h781, 32'd3);
        rd_chk("R13 host irq set", 12'h344, 32'h0000_0100);
        wr(12'h781, 32'd0);
        rd_chk("R13 host irq clear", 12'h344, 32'h0);
    endtask

    task automatic t_illegal;
        addr = 12'h7FF;
        #1;
        chk("R14 illegal flag", {31'b0, ill}, 32'h1);
        chk("R14 illegal reads zero", rdata, 32'h0);
        rd_chk("R14 known addr legal", 12'h340, 32'hDEAD_BEEF);
        chk("R14 legal flag low", {31'b0, ill}, 32'h0);
        wr(12'h7FF, 32'h0);
        rd_chk("R14 write no effect", 12'h340, 32'hDEAD_BEEF);
        rd_chk("R14 status untouched", 12'h300, 32'h0000_0008);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_sview();
        t_irq();
        t_regs();
        t_timer();
        t_time();
        t_ret();
        t_host();
        t_illegal();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule